// File: doc/BRIEF.md
# Serial-Port Sequencer for a 12-Bit Successive-Approximation Converter

This block is the digital core of a successive-approximation converter with a three-wire serial read port. It watches an active-low select line and a serial clock, both already synchronous to the system clock. It drives the capacitor-sample switch and steps a binary-weighted trial code into the DAC, resolving one bit of the result per serial clock. It reads one comparator decision each time. Each decided bit is put on the serial data line as soon as it is known. The comparator, the DAC and the hold capacitor sit outside the block.

After the last decision the stored word is sent back out, lowest bit first. The bit just sent is not repeated. When the replay is done the line carries zeros for as long as clocks arrive. Raising select ends the transfer, turns off the driver and returns to idle. The data bit and its output enable are separate outputs, so the tri-state pad is built outside the block. A phase output shows which part of the transfer is on the line.

Serial clock and select are sampled on the system clock. Every output reacts on the first system-clock edge that sees the new input level, which is one system clock after the change. The serial clock may idle low or idle high.

Top module: `sar_serial_seq`

## Requirements
- R1: A transfer starts only when select is seen to go from high to low. After reset with select low, no serial clock activity moves the phase off idle (0) or enables the output until select has been high and then low.
- R2: sample_o rises on the first rising serial clock edge after select falls and stays high until the second falling edge after it. Falling edges seen before that first rise are ignored.
- R3: On that second falling edge the output enable turns on and the data bit is 0 (null bit). Before it the output enable is off.
- R4: The next 12 falling edges (falls 3 to 14) carry result bits 11 down to 0. Bit k is found by adding bit k to the bits already decided, presenting that on dac_code_o, and keeping bit k when cmp_i is 1 (input at or above the DAC level). After fall 14, dac_code_o holds the full result.
- R5: sdo_o and sdo_oe_o change only in response to a falling serial clock edge or to select rising, never on a rising serial clock edge.
- R6: Falls 15 to 25 replay result bits 1 up to 11, in that order. Bit 0 is not sent twice.
- R7: From fall 26 onward, while select stays low, the data bit is 0.
- R8: When select is high, the output enable is off and the phase is idle one system clock later.
- R9: Each new select falling edge clears the result register. Until the null bit, dac_code_o reads 0 even after an aborted transfer.
- R10: phase_o encoding: 0 idle, 1 sample, 2 null, 3 MSB-first data, 4 LSB-first replay, 5 zero tail. It always names the part of the transfer that is currently on the line.
- R11: A serial clock that idles high gives the same bit sequence as one that idles low, counted from the first rising edge after select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select, synchronous to clk_i |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| cmp_i | input | 1 | Comparator decision: 1 when held input is at or above dac_code_o |
| dac_code_o | output | W (12) | Trial code during conversion, final result afterwards |
| sample_o | output | 1 | Sample switch closed |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (pad driven when 1) |
| phase_o | output | 3 | Current phase, encoded per R10 |

## Verification
The bench models the comparator as a plain compare of a held input code against dac_code_o. It then sweeps that code over a stride covering the whole range, plus all-zero, all-one, mid-scale and single-bit values. A wrong bit order, a bad trial bit or a missed keep/clear decision therefore shows up as a wrong serial bit at a known fall. Full-length transfers separate the MSB-first, replay and zero-tail sections. Short aborted transfers with all-ones inputs, followed by a new select, show whether stale result bits survive. Idle-high clock runs and a power-up with select low test edge counting and the lockout.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_NULL   = 3'd2,
    PH_MSB    = 3'd3,
    PH_LSB    = 3'd4,
    PH_ZERO   = 3'd5
  } phase_e;
endpackage

// File: rtl/sar_serial_edge.sv
module sar_serial_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= RST_VAL;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
  assign fall_o = ~d_i & d_q;
endmodule

// File: rtl/sar_serial_reg.sv
module sar_serial_reg #(
  parameter int W  = 12,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          dec_en_i,
  input  logic          trial_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  result_o,
  output logic [W-1:0]  dac_code_o
);
  logic [W-1:0] result_q;
  logic [W-1:0] trial_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       result_q <= '0;
    else if (clr_i)    result_q <= '0;
    else if (dec_en_i) result_q[idx_i] <= cmp_i;
  end

  assign trial_bit  = trial_en_i ? (W'(1) << idx_i) : '0;
  assign result_o   = result_q;
  assign dac_code_o = result_q | trial_bit;

  // Bits at and below the trial position are still undecided, so must be clear.
  assert_trial_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trial_en_i |-> ((result_q & ((W'(1) << idx_i) | ((W'(1) << idx_i) - W'(1)))) == '0));
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_serial_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         sclk_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_code_o,
  output logic         sample_o,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [2:0]   phase_o
);
  localparam int SW = $clog2(2 * W + 1);
  localparam int IW = $clog2(W);

  logic sel_evt, desel_evt, sck_rise, sck_fall;
  phase_e phase_q;
  logic armed_q, fall_seen_q, sdo_q, oe_q;
  logic [SW-1:0] step_q, step_nx, trial_pos, rep_pos;
  logic [IW-1:0] trial_idx;
  logic trial_en, dec_en;
  logic [W-1:0] result;

  // select reset as "low": a fall needs a high level first (power-up lockout)
  sar_serial_edge #(.RST_VAL(1'b0)) u_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni),
    .rise_o(desel_evt), .fall_o(sel_evt)
  );

  sar_serial_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  assign step_nx   = (step_q == SW'(2 * W)) ? step_q : step_q + SW'(1);
  assign trial_pos = SW'(W - 1) - step_q;
  assign trial_idx = trial_pos[IW-1:0];
  assign rep_pos   = step_nx - SW'(W);
  assign trial_en  = (phase_q == PH_NULL) || ((phase_q == PH_MSB) && (step_q < SW'(W)));
  assign dec_en    = trial_en && sck_fall && !sel_evt && !desel_evt;

  sar_serial_reg #(.W(W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sel_evt),
    .dec_en_i(dec_en), .trial_en_i(trial_en), .idx_i(trial_idx),
    .cmp_i(cmp_i), .result_o(result), .dac_code_o(dac_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      armed_q     <= 1'b0;
      fall_seen_q <= 1'b0;
      step_q      <= '0;
      sdo_q       <= 1'b0;
      oe_q        <= 1'b0;
    end else if (desel_evt) begin
      phase_q <= PH_IDLE;
      armed_q <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (sel_evt) begin
      phase_q     <= PH_IDLE;
      armed_q     <= 1'b1;
      fall_seen_q <= 1'b0;
      step_q      <= '0;
      sdo_q       <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (armed_q && sck_rise) begin
          phase_q <= PH_SAMPLE;
          armed_q <= 1'b0;
        end
        PH_SAMPLE: if (sck_fall) begin
          if (fall_seen_q) begin
            phase_q <= PH_NULL;
            oe_q    <= 1'b1;
            sdo_q   <= 1'b0;
            step_q  <= '0;
          end else begin
            fall_seen_q <= 1'b1;
          end
        end
        default: if (sck_fall) begin
          step_q <= step_nx;
          if (step_nx <= SW'(W)) begin
            phase_q <= PH_MSB;
            sdo_q   <= cmp_i;
          end else if (step_nx < SW'(2 * W)) begin
            phase_q <= PH_LSB;
            sdo_q   <= result[rep_pos[IW-1:0]];
          end else begin
            phase_q <= PH_ZERO;
            sdo_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign sample_o = (phase_q == PH_SAMPLE);
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign phase_o  = phase_q;

  assert_lockout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !armed_q && !sel_evt) |=> (phase_q == PH_IDLE));
  assert_sample_undriven_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !sdo_oe_o);
  assert_null_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NULL) |-> (sdo_oe_o && !sdo_o));
  assert_fall_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sdo_o != $past(sdo_o)) || (sdo_oe_o != $past(sdo_oe_o))) |-> $past(sck_fall || desel_evt));
  assert_result_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_LSB || phase_q == PH_ZERO) && !cs_ni) |=> $stable(dac_code_o));
  assert_zero_tail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ZERO) |-> !sdo_o);
  assert_deselect_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!sdo_oe_o && phase_q == PH_IDLE));
endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;
  localparam int W = 12;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic sclk = 1'b0;
  logic [W-1:0] vin = '0;
  logic cmp;
  logic [W-1:0] dac;
  logic sample, sdo, oe;
  logic [2:0] phase;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_serial_seq #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .cmp_i(cmp),
    .dac_code_o(dac), .sample_o(sample), .sdo_o(sdo), .sdo_oe_o(oe), .phase_o(phase)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int f);
    if (f == 1) return "R2";
    if (f == 2) return "R3";
    if (f <= 14) return "R4";
    if (f <= 25) return "R6";
    return "R7";
  endfunction

  // expected {phase, sample, oe, sdo} right after fall f
  function automatic logic [5:0] exp_of(input int f, input logic [W-1:0] v);
    logic [2:0] ph;
    logic d;
    d = 1'b0;
    if (f == 1) ph = 3'd1;
    else if (f == 2) ph = 3'd2;
    else if (f <= 14) begin ph = 3'd3; d = v[14-f]; end
    else if (f <= 25) begin ph = 3'd4; d = v[f-14]; end
    else ph = 3'd5;
    return {ph, (f == 1), (f >= 2), d};
  endfunction

  task automatic run_xfer(input logic [W-1:0] v, input bit idle_hi, input int nfall);
    logic [5:0] e;
    logic [5:0] a;
    logic p_oe, p_sdo;
    vin = v;
    sclk = idle_hi;
    wait_clks(2);
    cs_n = 1'b0;
    wait_clks(H);
    chk(dac == '0 && !oe && !sample && phase == 3'd0, "R9", "clear on select",
        {dac, oe, sample}, 0);
    if (idle_hi) begin
      sclk = 1'b0;
      wait_clks(H);
      chk(!sample && !oe && phase == 3'd0, "R11", "leading fall ignored",
          {phase, sample, oe}, 0);
    end
    p_oe = 1'b0;
    p_sdo = 1'b0;
    for (int f = 1; f <= nfall; f++) begin
      sclk = 1'b1;
      wait_clks(H);
      chk(sample == (f <= 2), "R2", "sample during high half", sample, (f <= 2));
      chk(oe == p_oe && sdo == p_sdo, "R5", "no change on rise", {oe, sdo}, {p_oe, p_sdo});
      sclk = 1'b0;
      wait_clks(H);
      e = exp_of(f, v);
      a = {phase, sample, oe, sdo};
      chk(a == e, tag_of(f), idle_hi ? "fall R11 mode" : "fall R10 phase", a, e);
      p_oe = oe;
      p_sdo = sdo;
    end
    if (nfall >= 14) chk(dac == v, "R4", "final result", dac, v);
    if (idle_hi) begin
      sclk = 1'b1;
      wait_clks(H);
    end
    cs_n = 1'b1;
    wait_clks(2);
    chk(!oe && phase == 3'd0, "R8", "deselect idle", {phase, oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(1);
    chk(phase == 3'd0 && !oe && !sample && dac == '0, "R10", "reset state",
        {phase, oe, sample, dac}, 0);
    // power-up with select low: clocks must do nothing
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk;
      wait_clks(H);
      chk(phase == 3'd0 && !oe && !sample, "R1", "locked out", {phase, oe, sample}, 0);
    end
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clks(H);
    // full-length sweep, clock idle low
    for (int k = 0; k <= 240; k++) run_xfer(W'(k * 17), 1'b0, 30);
    run_xfer(12'hFFF, 1'b0, 30);
    run_xfer(12'h800, 1'b0, 30);
    run_xfer(12'h7FF, 1'b0, 30);
    for (int b = 0; b < W; b++) run_xfer(W'(1) << b, 1'b0, 28);
    // aborted transfers then fresh ones
    run_xfer(12'hFFF, 1'b0, 8);
    run_xfer(12'h000, 1'b0, 16);
    run_xfer(12'hFFF, 1'b0, 13);
    run_xfer(12'h5A3, 1'b0, 16);
    // clock idle high
    for (int k = 0; k < 16; k++) run_xfer(W'(k * 273), 1'b1, 28);
    run_xfer(12'hFFF, 1'b1, 30);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule